// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block takes configuration words from a host over a one-way serial link. The link has three lines: a data line, a serial clock and an active-low enable. All three lines enter the block's own system clock domain through a synchronizer. The block then looks for rising edges of the serial clock. Each edge seen while the enable is low shifts the data bit into a 24-bit shift register. The bit sent first travels towards the top position (bit 23), and the bit sent last lands in bit 0.

When the enable returns high, the shift register contents are copied into a holding register, and a strobe goes high for one system clock cycle. The holding register drives the decoded control fields:
- a 7-bit main divider value,
- a 2-bit reference ratio code,
- a slicer enable,
- a 2-bit operating mode,
- a loop-hold flag,
- a transmit/receive select.

Eleven bit positions are reserved and must be sent as zero. A word that arrives with any of them set raises an error flag, which stays high until reset. The decoded fields of that word are still applied.

Top module: `ser3w_cfg`

## Requirements
- R1: While `rst` is high (synchronous, active high), every decoded output, `test_err` and `upd_strobe` are driven to 0.
- R2: A serial data bit is taken only on a rising edge of `ser_clk` seen while `ser_en_n` is low. Clock edges while `ser_en_n` is high change neither the outputs nor the shift register contents.
- R3: Each accepted bit enters at bit 0 and moves everything already held up by one place, so the first bit of a 24-bit burst ends at bit 23. Bits shifted out above bit 23 are lost, and a burst of any length is accepted. A burst shorter than 24 bits leaves older bits in the upper positions, and a burst with no clocks reloads the previous word unchanged.
- R4: Every rising edge of `ser_en_n` copies the shift register into the holding register. `upd_strobe` is high for exactly one clock cycle per transfer, in the first cycle in which the new outputs are visible.
- R5: Fields of the held word (bit positions):
  - `slicer_on` is bit 19.
  - `ref_code` is bits 18:17.
  - `op_mode` is {bit 9, bit 7}, where 00 means parallel control, 01 means serial control ended by enable, 10 is reserved, and 11 means serial control ended by the external power line.
  - `loop_hold` is bit 8.
  - `tx_rx` is bit 6.
- R6: `div_val` is {bits 5:0, bit 6}: bit 5 is the MSB and the transmit/receive bit is the LSB.
- R7: A transferred word with any of bits 23:20 or 16:10 set sets `test_err`, which then stays high until reset. The fields of that word are still applied.
- R8: A serial clock rise that reaches the synchronized domain in the same cycle as the enable rise is not shifted in. The transferred word excludes that bit.
- R9: The decoded outputs change only in a cycle in which `upd_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_dat | input | 1 | Serial data from host (asynchronous) |
| ser_en_n | input | 1 | Active-low burst enable from host (asynchronous) |
| div_val | output | 7 | Main divider value |
| ref_code | output | 2 | Reference ratio code |
| slicer_on | output | 1 | Slicer enable |
| op_mode | output | 2 | Operating mode code |
| loop_hold | output | 1 | Keep loop closed while oscillator runs |
| tx_rx | output | 1 | Transmit/receive select bit |
| test_err | output | 1 | Sticky flag: a reserved bit was received as 1 |
| upd_strobe | output | 1 | One-cycle pulse when new fields are applied |

## Verification
The serial clock rise and the enable rise can reach the synchronized domain in the same cycle. In that cycle the shift must be suppressed while the transfer still takes place. The bench provokes this by raising `ser_clk` and `ser_en_n` on the same clock edge, and then checks that the applied word leaves out the bit presented with that clock rise. Two other events also share a cycle, the error flag rising and the strobe: a word with one reserved bit set must raise `test_err` in the strobe cycle, and its fields must still be applied.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    localparam int WORD_W = 24;
    localparam int DIV_W  = 7;

    // Received word; field order follows the bit order on the wire
    typedef struct packed {
        logic [3:0] tst_hi;
        logic       slicer;
        logic [1:0] ref_sel;
        logic [6:0] tst_lo;
        logic       pwr_sel;
        logic       loop_hold;
        logic       seq_sel;
        logic       txrx;
        logic [5:0] div_hi;
    } cfg_word_t;

    typedef enum logic [1:0] {
        MODE_PARALLEL   = 2'b00,
        MODE_SERIAL_EN  = 2'b01,
        MODE_RESERVED   = 2'b10,
        MODE_SERIAL_PWR = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [1:0]       ref_code;
        logic             slicer;
        op_mode_e         mode;
        logic             loop_hold;
        logic             txrx;
    } cfg_out_t;

    localparam cfg_out_t CFG_RESET = '0;

    function automatic logic has_test_bits(cfg_word_t w);
        return (|w.tst_hi) | (|w.tst_lo);
    endfunction

    function automatic cfg_out_t decode_word(cfg_word_t w);
        cfg_out_t o;
        o.div       = {w.div_hi, w.txrx};
        o.ref_code  = w.ref_sel;
        o.slicer    = w.slicer;
        o.mode      = op_mode_e'({w.pwr_sel, w.seq_sel});
        o.loop_hold = w.loop_hold;
        o.txrx      = w.txrx;
        return o;
    endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ser3w_shift.sv
module ser3w_shift
    import ser3w_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_s,
    input  logic      sdat_s,
    input  logic      sen_n_s,
    output cfg_word_t word_q,
    output logic      load_p
);
    logic sclk_d;
    logic sen_n_d;
    logic take_bit;

    assign take_bit = sclk_s & ~sclk_d & ~sen_n_s;
    assign load_p   = sen_n_s & ~sen_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            sen_n_d <= 1'b1;
            word_q  <= '0;
        end else begin
            sclk_d  <= sclk_s;
            sen_n_d <= sen_n_s;
            if (take_bit)
                word_q <= cfg_word_t'({word_q[WORD_W-2:0], sdat_s});
        end
    end
endmodule

// File: rtl/ser3w_hold.sv
module ser3w_hold
    import ser3w_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_p,
    input  cfg_word_t word,
    output cfg_out_t  cfg_q,
    output logic      err_q,
    output logic      strobe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RESET;
            err_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= load_p;
            if (load_p) begin
                cfg_q <= decode_word(word);
                err_q <= err_q | has_test_bits(word);
            end
        end
    end
endmodule

// File: rtl/ser3w_cfg.sv
module ser3w_cfg
    import ser3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_en_n,
    output logic [DIV_W-1:0] div_val,
    output logic [1:0]       ref_code,
    output logic             slicer_on,
    output logic [1:0]       op_mode,
    output logic             loop_hold,
    output logic             tx_rx,
    output logic             test_err,
    output logic             upd_strobe
);
    localparam int          LINES    = 3;
    localparam logic [2:0]  LINE_RST = 3'b100;   // {enable, clock, data}

    logic [LINES-1:0] lines_s;
    cfg_word_t        word;
    logic             load_p;
    cfg_out_t         cfg;

    ser3w_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_en_n, ser_clk, ser_dat}),
        .dout (lines_s)
    );

    ser3w_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (lines_s[1]),
        .sdat_s  (lines_s[0]),
        .sen_n_s (lines_s[2]),
        .word_q  (word),
        .load_p  (load_p)
    );

    ser3w_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_p   (load_p),
        .word     (word),
        .cfg_q    (cfg),
        .err_q    (test_err),
        .strobe_q (upd_strobe)
    );

    assign div_val   = cfg.div;
    assign ref_code  = cfg.ref_code;
    assign slicer_on = cfg.slicer;
    assign op_mode   = cfg.mode;
    assign loop_hold = cfg.loop_hold;
    assign tx_rx     = cfg.txrx;
endmodule

// File: rtl/ser3w_cfg_chk.sv
module ser3w_cfg_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] div_val,
    input logic [1:0] ref_code,
    input logic       slicer_on,
    input logic [1:0] op_mode,
    input logic       loop_hold,
    input logic       tx_rx,
    input logic       test_err,
    input logic       upd_strobe
);
    // R1: reset clears strobe, error flag and divider value
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!upd_strobe && !test_err && div_val == 7'd0));

    // R4: strobe never lasts more than one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    // R9: decoded outputs stay put outside strobe cycles
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_strobe |-> $stable({div_val, ref_code, slicer_on, op_mode, loop_hold, tx_rx}));

    // R7: error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        test_err |=> test_err);

    // R7: error flag can only rise together with a transfer
    p_err_rise_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(test_err) |-> upd_strobe);
endmodule

bind ser3w_cfg ser3w_cfg_chk i_ser3w_cfg_chk (
    .clk        (clk),
    .rst        (rst),
    .div_val    (div_val),
    .ref_code   (ref_code),
    .slicer_on  (slicer_on),
    .op_mode    (op_mode),
    .loop_hold  (loop_hold),
    .tx_rx      (tx_rx),
    .test_err   (test_err),
    .upd_strobe (upd_strobe)
);

// File: tb/test_ser3w_cfg.sv
module test_ser3w_cfg;
    localparam int HALF = 4;   // serial half period in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_en_n = 1'b1;
    logic [6:0] div_val;
    logic [1:0] ref_code;
    logic       slicer_on;
    logic [1:0] op_mode;
    logic       loop_hold;
    logic       tx_rx;
    logic       test_err;
    logic       upd_strobe;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 0;

    logic [23:0] shadow = '0;
    logic [23:0] held = '0;
    logic        err_exp = 1'b0;

    always #2.5 clk = ~clk;

    ser3w_cfg i_ser3w_cfg (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
        .div_val(div_val), .ref_code(ref_code), .slicer_on(slicer_on), .op_mode(op_mode),
        .loop_hold(loop_hold), .tx_rx(tx_rx), .test_err(test_err), .upd_strobe(upd_strobe)
    );

    always @(negedge clk) if (upd_strobe) strobes++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_fields(input string tag);
        chk({tag, " R6 div_val"},   div_val,   {held[5:0], held[6]});
        chk({tag, " R5 ref_code"},  ref_code,  held[18:17]);
        chk({tag, " R5 slicer_on"}, slicer_on, held[19]);
        chk({tag, " R5 op_mode"},   op_mode,   {held[9], held[7]});
        chk({tag, " R5 loop_hold"}, loop_hold, held[8]);
        chk({tag, " R5 tx_rx"},     tx_rx,     held[6]);
        chk({tag, " R7 test_err"},  test_err,  err_exp);
    endtask

    task automatic send_bit(input logic b);
        ser_clk = 1'b0; ser_dat = b;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        if (!ser_en_n) shadow = {shadow[22:0], b};
    endtask

    task automatic end_frame(input string tag);
        int s0;
        ser_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        s0 = strobes;
        ser_en_n = 1'b1;
        held = shadow;
        err_exp = err_exp | (|held[23:20]) | (|held[16:10]);
        repeat (10) @(negedge clk);
        chk({tag, " R4 one strobe cycle"}, strobes - s0, 1);
        check_fields(tag);
    endtask

    task automatic frame(input logic [63:0] bits, input int n, input string tag);
        @(negedge clk);
        ser_en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        end_frame(tag);
    endtask

    function automatic logic [23:0] mk_word(input int n);
        logic [6:0] d;
        logic [23:0] w;
        d = n[6:0];
        w = '0;
        w[5:0]   = d[6:1];
        w[6]     = d[0];
        w[19]    = d[3];
        w[18:17] = d[5:4];
        w[9]     = d[1];
        w[8]     = d[2];
        w[7]     = d[6];
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 strobe", upd_strobe, 0);
        check_fields("R1 reset");

        // R3 R5 R6: sweep every divider value with varied flags
        for (int n = 0; n < 128; n++) frame({40'd0, mk_word(n)}, 24, "sweep");

        // R3: leading extra ones fall off; no error raised
        frame({34'd0, 6'h3F, 24'h0A_02C5}, 30, "R3 leading bits");

        // R2: clock edges with enable high are ignored
        s0 = strobes;
        for (int i = 0; i < 20; i++) send_bit(i[0]);
        ser_clk = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 no strobe while idle", strobes - s0, 0);
        check_fields("R2 idle clocks");
        frame(64'd0, 0, "R2 empty burst keeps shift contents");

        // R8: last clock rise coincides with enable rise
        @(negedge clk);
        ser_en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 23; i >= 0; i--) send_bit(mk_word(77)[i]);
        ser_clk = 1'b0; ser_dat = 1'b1;
        repeat (HALF) @(negedge clk);
        s0 = strobes;
        ser_clk = 1'b1; ser_en_n = 1'b1;
        held = shadow;
        repeat (10) @(negedge clk);
        chk("R8 strobe", strobes - s0, 1);
        check_fields("R8 coincident edge");

        // R7: reserved bit set -> sticky error, fields applied
        frame({40'd0, mk_word(93) | 24'h00_1000}, 24, "R7 reserved bit");
        chk("R7 error raised", test_err, 1);
        frame({40'd0, mk_word(18)}, 24, "R7 sticky after clean word");

        // R3: short burst leaves older bits above
        frame({54'd0, 10'b1010011101}, 10, "R3 short burst");

        // R1: mid-run reset
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        shadow = '0; held = '0; err_exp = 1'b0;
        @(negedge clk);
        check_fields("R1 second reset");
        frame(64'd0, 0, "R1 shift register cleared");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule